// File: doc/BRIEF.md
# CPU Memory Access Front End

This block sits between an 8-bit processor core and three storage regions: a read-only program region, a read/write data region, and a small bank of memory-mapped I/O registers. It builds the data address from a page byte and a base-plus-offset byte. It chooses between that data address and the instruction fetch address, and decodes which region responds. Read bytes are returned to the core through per-region valid flags, and write strobes go only to a region that can be written. The storage arrays are not part of the block. The bench models them.

Instructions are 16 bits wide and are stored as two bytes, high byte first. A small sequencer reads the two bytes in two consecutive cycles, builds the instruction, and signals completion with a one-cycle pulse. It has three phases. The states are `PH_IDLE`, `PH_HIGH` and `PH_LOW`, with these transitions:
- `PH_IDLE` goes to `PH_HIGH` when `fetch_req` is high.
- `PH_HIGH` goes to `PH_LOW` when no data access is active. During a data access it stays in `PH_HIGH`.
- `PH_LOW` goes to `PH_IDLE` when no data access is active, and raises `instr_done` in the next cycle. During a data access it stays in `PH_LOW`.

A data access always takes the address bus from the sequencer. Any phase the access interrupts is held until the access ends.

Top module: `mafe_top`

## Requirements
- R1: When `data_access` is high, `mem_addr` is `{page, (base + imm) mod 256}`. A carry out of the low-byte sum never changes the upper byte.
- R2: When `data_access` is low, `mem_addr` is the fetch address. The fetch address is `pc`, except in phase `PH_LOW`, where it is `pc + 1`.
- R3: Region decode works as follows. Addresses 0x0000–0x0FFF assert `rom_sel`, and 0x1000–0x1FFF assert `ram_sel`. Addresses 0xFFFC–0xFFFF assert `io_sel`, with `io_port = mem_addr[1:0]`. Every other address asserts no select.
- R4: A store is `store` high while `data_access` is high. A store raises `ram_we` only when `ram_sel` is high, and raises `io_we` only when `io_sel` is high. A store to the ROM region or to an unmapped address raises neither strobe and changes no stored byte. `mem_wdata` equals `wdata`.
- R5: The ROM region's data is valid whenever `rom_sel` is high. The RAM and I/O regions' data is valid only when that region is selected and no store is in progress.
- R6: `rd_data` returns the byte of the region whose data is valid, and `rd_valid` is high. When no region is valid, `rd_data` is 0x00 and `rd_valid` is low.
- R7: When `fetch_req` is seen in `PH_IDLE`, the byte at `pc` is read in the next cycle and the byte at `pc + 1` in the cycle after. In the cycle after that, `instr` equals `{byte(pc), byte(pc+1)}` and `instr_done` is high for exactly one cycle.
- R8: A data access during `PH_HIGH` or `PH_LOW` holds the phase and captures no fetch byte. The fetch completes with the correct instruction once the access ends.
- R9: Synchronous active-high `rst` returns the sequencer to `PH_IDLE`, clears `instr` to 0x0000, and holds `instr_done` low. After reset, `mem_addr` follows `pc`, so execution starts from `pc = 0`.
- R10: A fetch may read from RAM, I/O or unmapped addresses. It takes whatever byte is returned, and an unmapped address gives 0x00.
- R11: The second fetch address wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc | input | 16 | Program counter from the core |
| data_access | input | 1 | A load or store is active this cycle |
| store | input | 1 | The access is a store |
| page | input | 8 | Page byte, the upper address byte |
| base | input | 8 | Base register value |
| imm | input | 8 | 8-bit immediate offset |
| wdata | input | 8 | Store data from the core |
| fetch_req | input | 1 | Start a two-byte instruction fetch |
| mem_addr | output | 16 | Address presented to all regions |
| rom_sel | output | 1 | ROM region selected |
| ram_sel | output | 1 | RAM region selected |
| io_sel | output | 1 | I/O bank selected |
| io_port | output | 2 | I/O register index |
| ram_we | output | 1 | RAM write strobe |
| io_we | output | 1 | I/O write strobe |
| mem_wdata | output | 8 | Write data to the regions |
| rom_rdata | input | 8 | ROM read byte |
| ram_rdata | input | 8 | RAM read byte |
| io_rdata | input | 8 | I/O read byte |
| rd_data | output | 8 | Steered read byte to the core |
| rd_valid | output | 1 | `rd_data` is valid |
| fetch_busy | output | 1 | Sequencer is outside `PH_IDLE` |
| instr | output | 16 | Last assembled instruction |
| instr_done | output | 1 | One-cycle pulse when `instr` is updated |

## Verification
A data load or store can arrive in the same cycle as an instruction fetch phase, and the two then compete for the shared address bus. The bench raises `data_access` while the sequencer is in `PH_HIGH`, and again while it is in `PH_LOW`. In those cycles it checks that `mem_addr` shows the effective data address and that no completion pulse appears. It then releases the access and checks three things:
- the sequencer resumes at the held address;
- `instr_done` rises exactly one cycle after the low byte is read;
- `instr` contains the bytes at `pc` and `pc + 1`, not the byte read by the data access.

// File: rtl/mafe_pkg.sv
package mafe_pkg;

    // Instruction fetch phases
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } fetch_phase_e;

    // One flag per storage region
    typedef struct packed {
        logic io;
        logic ram;
        logic rom;
    } region_flags_t;

endpackage

// File: rtl/mafe_addr_gen.sv
module mafe_addr_gen #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        pc,
    input  logic [AW-DW-1:0]     page,
    input  logic [DW-1:0]        base,
    input  logic [DW-1:0]        imm,
    input  logic                 data_access,
    input  logic                 fetch_second,
    output logic [AW-1:0]        addr
);
    localparam int PAGE_W = AW - DW;

    logic [DW-1:0] low_byte;
    logic [AW-1:0] eff_addr;
    logic [AW-1:0] fetch_addr;

    // 8-bit wrapping sum, carry discarded
    always_comb begin
        low_byte = base + imm;
        eff_addr = {page, low_byte};
    end

    always_comb begin
        if (fetch_second)
            fetch_addr = pc + AW'(1);
        else
            fetch_addr = pc;
    end

    always_comb begin
        if (data_access)
            addr = eff_addr;
        else
            addr = fetch_addr;
    end

    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        data_access |-> addr[AW-1:DW] == PAGE_W'(page)); // R1

endmodule

// File: rtl/mafe_region_dec.sv
module mafe_region_dec
    import mafe_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          IO_PORTS = 4,
    parameter int          REGION_W = 4,
    parameter logic [3:0]  ROM_TAG  = 4'h0,
    parameter logic [3:0]  RAM_TAG  = 4'h1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [AW-1:0]                 addr,
    output region_flags_t                 sel,
    output logic [$clog2(IO_PORTS)-1:0]   io_idx
);
    localparam int IDX_W = $clog2(IO_PORTS);
    localparam int HI_W  = AW - IDX_W;

    logic [REGION_W-1:0] tag;
    logic [HI_W-1:0]     io_hi;

    always_comb begin
        tag     = addr[AW-1 -: REGION_W];
        io_hi   = addr[AW-1:IDX_W];
        sel.rom = (tag == REGION_W'(ROM_TAG));
        sel.ram = (tag == REGION_W'(RAM_TAG));
        sel.io  = &io_hi;
        io_idx  = addr[IDX_W-1:0];
    end

    AST_ONE_REGION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel.io, sel.ram, sel.rom})); // R3

endmodule

// File: rtl/mafe_read_steer.sv
module mafe_read_steer
    import mafe_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  region_flags_t  sel,
    input  logic           storing,
    input  logic [DW-1:0]  rom_rdata,
    input  logic [DW-1:0]  ram_rdata,
    input  logic [DW-1:0]  io_rdata,
    output logic [DW-1:0]  rd_data,
    output logic           rd_valid
);
    region_flags_t valid;

    always_comb begin
        valid.rom = sel.rom;
        valid.ram = sel.ram & ~storing;
        valid.io  = sel.io  & ~storing;
    end

    // AND-OR steering: an invalid region contributes zero
    always_comb begin
        rd_data  = ({DW{valid.rom}} & rom_rdata)
                 | ({DW{valid.ram}} & ram_rdata)
                 | ({DW{valid.io}}  & io_rdata);
        rd_valid = valid.rom | valid.ram | valid.io;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> rd_data == '0); // R6
    AST_STORE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (storing && !sel.rom) |-> !rd_valid); // R5

endmodule

// File: rtl/mafe_fetch_seq.sv
module mafe_fetch_seq
    import mafe_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fetch_req,
    input  logic            data_access,
    input  logic [DW-1:0]   rd_data,
    output logic            fetch_second,
    output logic            busy,
    output logic [2*DW-1:0] instr,
    output logic            instr_done
);
    fetch_phase_e state_q, state_d;
    logic [DW-1:0]   hi_q;
    logic [2*DW-1:0] instr_q;
    logic            done_q;

    // Next-phase logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (fetch_req)    state_d = PH_HIGH;
            PH_HIGH: if (!data_access) state_d = PH_LOW;
            PH_LOW:  if (!data_access) state_d = PH_IDLE;
            default:                   state_d = PH_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PH_IDLE;
        else
            state_q <= state_d;
    end

    // Output register process: byte capture and completion pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            instr_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                PH_IDLE: ;
                PH_HIGH: if (!data_access) hi_q <= rd_data;
                PH_LOW: begin
                    if (!data_access) begin
                        instr_q <= {hi_q, rd_data};
                        done_q  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        fetch_second = (state_q == PH_LOW);
        busy         = (state_q != PH_IDLE);
        instr        = instr_q;
        instr_done   = done_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        instr_done |=> !instr_done); // R7
    AST_DONE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        instr_done |-> ($past(state_q) == PH_LOW && !$past(data_access))); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != PH_IDLE && data_access) |=> (state_q == $past(state_q))); // R8

endmodule

// File: rtl/mafe_top.sv
module mafe_top
    import mafe_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int IO_PORTS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [AW-1:0]                 pc,
    input  logic                          data_access,
    input  logic                          store,
    input  logic [AW-DW-1:0]              page,
    input  logic [DW-1:0]                 base,
    input  logic [DW-1:0]                 imm,
    input  logic [DW-1:0]                 wdata,
    input  logic                          fetch_req,
    output logic [AW-1:0]                 mem_addr,
    output logic                          rom_sel,
    output logic                          ram_sel,
    output logic                          io_sel,
    output logic [$clog2(IO_PORTS)-1:0]   io_port,
    output logic                          ram_we,
    output logic                          io_we,
    output logic [DW-1:0]                 mem_wdata,
    input  logic [DW-1:0]                 rom_rdata,
    input  logic [DW-1:0]                 ram_rdata,
    input  logic [DW-1:0]                 io_rdata,
    output logic [DW-1:0]                 rd_data,
    output logic                          rd_valid,
    output logic                          fetch_busy,
    output logic [2*DW-1:0]               instr,
    output logic                          instr_done
);
    region_flags_t sel;
    logic          fetch_second;
    logic          storing;

    always_comb storing = data_access & store;

    mafe_addr_gen #(.AW(AW), .DW(DW)) u_addr (
        .clk          (clk),
        .rst          (rst),
        .pc           (pc),
        .page         (page),
        .base         (base),
        .imm          (imm),
        .data_access  (data_access),
        .fetch_second (fetch_second),
        .addr         (mem_addr)
    );

    mafe_region_dec #(.AW(AW), .IO_PORTS(IO_PORTS)) u_dec (
        .clk    (clk),
        .rst    (rst),
        .addr   (mem_addr),
        .sel    (sel),
        .io_idx (io_port)
    );

    mafe_read_steer #(.DW(DW)) u_steer (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .storing   (storing),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .io_rdata  (io_rdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    mafe_fetch_seq #(.DW(DW)) u_fetch (
        .clk          (clk),
        .rst          (rst),
        .fetch_req    (fetch_req),
        .data_access  (data_access),
        .rd_data      (rd_data),
        .fetch_second (fetch_second),
        .busy         (fetch_busy),
        .instr        (instr),
        .instr_done   (instr_done)
    );

    // Write strobes: only writable regions receive one
    always_comb begin
        rom_sel   = sel.rom;
        ram_sel   = sel.ram;
        io_sel    = sel.io;
        ram_we    = storing & sel.ram;
        io_we     = storing & sel.io;
        mem_wdata = wdata;
    end

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(ram_sel || io_sel) |-> !(ram_we || io_we)); // R4
    AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (rst)
        (fetch_second && !data_access) |-> mem_addr == pc + AW'(1)); // R11
    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!fetch_second && !data_access) |-> mem_addr == pc); // R2

endmodule

// File: tb/sim_mafe_top.sv
`timescale 1ns/1ps
module sim_mafe_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] pc;
    logic        data_access, store, fetch_req;
    logic [7:0]  page, base, imm, wdata;
    logic [15:0] mem_addr;
    logic        rom_sel, ram_sel, io_sel, ram_we, io_we, rd_valid, fetch_busy, instr_done;
    logic [1:0]  io_port;
    logic [7:0]  mem_wdata, rom_rdata, ram_rdata, io_rdata, rd_data;
    logic [15:0] instr;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] ram_m [256];
    logic [7:0] io_m  [4];

    always #2 clk = ~clk;

    mafe_top u0 (
        .clk(clk), .rst(rst), .pc(pc), .data_access(data_access), .store(store),
        .page(page), .base(base), .imm(imm), .wdata(wdata), .fetch_req(fetch_req),
        .mem_addr(mem_addr), .rom_sel(rom_sel), .ram_sel(ram_sel), .io_sel(io_sel),
        .io_port(io_port), .ram_we(ram_we), .io_we(io_we), .mem_wdata(mem_wdata),
        .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .io_rdata(io_rdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .fetch_busy(fetch_busy),
        .instr(instr), .instr_done(instr_done)
    );

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    // Behavioural storage models
    always_comb begin
        rom_rdata = rom_byte(mem_addr);
        ram_rdata = ram_m[mem_addr[7:0]];
        io_rdata  = io_m[io_port];
    end

    always @(posedge clk) begin
        if (ram_we) ram_m[mem_addr[7:0]] <= mem_wdata;
        if (io_we)  io_m[io_port]       <= mem_wdata;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        data_access = 1'b0; store = 1'b0; fetch_req = 1'b0;
        page = 8'h00; base = 8'h00; imm = 8'h00; wdata = 8'h00;
    endtask

    task automatic set_data(input logic [7:0] p, input logic [7:0] b, input logic [7:0] i, input logic st);
        data_access = 1'b1; store = st; page = p; base = b; imm = i;
    endtask

    task automatic t_reset();
        rst = 1'b1; pc = 16'h0000; idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R9 done in reset", {15'd0, instr_done}, 16'd0);
        chk("R9 instr cleared", instr, 16'h0000);
        chk("R9 busy in reset", {15'd0, fetch_busy}, 16'd0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R9 start address", mem_addr, 16'h0000);
        chk("R3 rom at zero", {15'd0, rom_sel}, 16'd1);
    endtask

    task automatic t_eff_addr();
        @(negedge clk);
        set_data(8'h12, 8'hF0, 8'h20, 1'b0); #1;
        chk("R1 wrap keeps page", mem_addr, 16'h1210);
        set_data(8'h00, 8'h01, 8'hFF, 1'b0); #1;
        chk("R1 wrap to zero low", mem_addr, 16'h0000);
        set_data(8'h10, 8'h30, 8'h10, 1'b0); #1;
        chk("R1 plain sum", mem_addr, 16'h1040);
        data_access = 1'b0; pc = 16'h0ABC; #1;
        chk("R2 pc when no access", mem_addr, 16'h0ABC);
        pc = 16'h0000;
    endtask

    task automatic t_decode();
        logic [15:0] addrs [8];
        logic [2:0]  exp   [8];
        addrs = '{16'h0FFF, 16'h1000, 16'h1FFF, 16'h2000, 16'hFFFB, 16'hFFFC, 16'hFFFF, 16'h8000};
        exp   = '{3'b001,   3'b010,   3'b010,   3'b000,   3'b000,   3'b100,   3'b100,   3'b000};
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            set_data(addrs[k][15:8], addrs[k][7:0], 8'h00, 1'b0); #1;
            chk("R3 select", {13'd0, io_sel, ram_sel, rom_sel}, {13'd0, exp[k]});
        end
        set_data(8'hFF, 8'hFD, 8'h00, 1'b0); #1;
        chk("R3 io port index", {14'd0, io_port}, 16'd1);
        set_data(8'h80, 8'h00, 8'h00, 1'b0); #1;
        chk("R6 unmapped data zero", {8'd0, rd_data}, 16'h0000);
        chk("R6 unmapped not valid", {15'd0, rd_valid}, 16'd0);
        set_data(8'h03, 8'h20, 8'h01, 1'b0); #1;
        chk("R5 rom read", {7'd0, rd_valid, rd_data}, {7'd0, 1'b1, rom_byte(16'h0321)});
        data_access = 1'b0;
    endtask

    task automatic do_store(input logic [7:0] p, input logic [7:0] b, input logic [7:0] d);
        @(negedge clk);
        set_data(p, b, 8'h00, 1'b1); wdata = d;
        @(negedge clk);
        data_access = 1'b0; store = 1'b0;
    endtask

    task automatic t_store();
        @(negedge clk);
        set_data(8'h10, 8'h30, 8'h10, 1'b1); wdata = 8'h9D; #1;
        chk("R4 ram strobe", {14'd0, io_we, ram_we}, 16'b01);
        chk("R4 wdata forwarded", {8'd0, mem_wdata}, 16'h009D);
        chk("R5 ram no valid on store", {15'd0, rd_valid}, 16'd0);
        @(negedge clk);
        store = 1'b0; #1;
        chk("R5 ram readback", {7'd0, rd_valid, rd_data}, {7'd0, 1'b1, 8'h9D});
        set_data(8'hFF, 8'hF0, 8'h0E, 1'b1); wdata = 8'h3C; #1;
        chk("R4 io strobe", {13'd0, io_port, io_we, ram_we}, {13'd0, 2'd2, 1'b1, 1'b0});
        chk("R5 io no valid on store", {15'd0, rd_valid}, 16'd0);
        @(negedge clk);
        store = 1'b0; #1;
        chk("R6 io readback", {7'd0, rd_valid, rd_data}, {7'd0, 1'b1, 8'h3C});
        set_data(8'h00, 8'h40, 8'h00, 1'b1); wdata = 8'hEE; #1;
        chk("R4 rom store no strobe", {14'd0, io_we, ram_we}, 16'd0);
        chk("R5 rom valid during store", {15'd0, rd_valid}, 16'd1);
        @(negedge clk);
        set_data(8'h20, 8'h40, 8'h00, 1'b1); wdata = 8'hEE; #1;
        chk("R4 unmapped store no strobe", {14'd0, io_we, ram_we}, 16'd0);
        @(negedge clk);
        set_data(8'h10, 8'h40, 8'h00, 1'b0); #1;
        chk("R4 ram unchanged after ignored store", {8'd0, rd_data}, 16'h009D);
        set_data(8'h00, 8'h40, 8'h00, 1'b0); #1;
        chk("R4 rom byte after ignored store", {8'd0, rd_data}, {8'd0, rom_byte(16'h0040)});
        data_access = 1'b0;
    endtask

    task automatic do_fetch(input string req, input logic [15:0] p, input logic [15:0] exp);
        @(negedge clk);
        pc = p; fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0; #1;
        chk({req, " first addr"}, mem_addr, p);
        @(negedge clk); #1;
        chk({req, " second addr"}, mem_addr, p + 16'd1);
        chk({req, " no early done"}, {15'd0, instr_done}, 16'd0);
        @(negedge clk); #1;
        chk({req, " done pulse"}, {15'd0, instr_done}, 16'd1);
        chk({req, " instr"}, instr, exp);
        @(negedge clk); #1;
        chk({req, " pulse ends"}, {15'd0, instr_done}, 16'd0);
    endtask

    task automatic t_fetch();
        do_fetch("R7 rom fetch", 16'h0010, {rom_byte(16'h0010), rom_byte(16'h0011)});
        do_store(8'h10, 8'h41, 8'h77);
        do_fetch("R10 ram fetch", 16'h1040, 16'h9D77);
        do_store(8'hFF, 8'hFF, 8'hC3);
        do_fetch("R11 wrap fetch", 16'hFFFF, {8'hC3, rom_byte(16'h0000)});
        do_fetch("R10 unmapped fetch", 16'h4000, 16'h0000);
    endtask

    task automatic t_stall();
        @(negedge clk);
        pc = 16'h0020; fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        set_data(8'h10, 8'h40, 8'h00, 1'b0); #1;
        chk("R8 data wins in high phase", mem_addr, 16'h1040);
        @(negedge clk);
        data_access = 1'b0; #1;
        chk("R8 high phase held", mem_addr, 16'h0020);
        @(negedge clk);
        set_data(8'h10, 8'h41, 8'h00, 1'b0); #1;
        chk("R8 data wins in low phase", mem_addr, 16'h1041);
        @(negedge clk); #1;
        chk("R8 no done while stalled", {15'd0, instr_done}, 16'd0);
        data_access = 1'b0; #1;
        chk("R8 low phase held", mem_addr, 16'h0021);
        @(negedge clk); #1;
        chk("R8 done after release", {15'd0, instr_done}, 16'd1);
        chk("R8 instr after stall", instr, {rom_byte(16'h0020), rom_byte(16'h0021)});
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        pc = 16'h0030; fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; #1;
        chk("R9 reset mid fetch idle addr", mem_addr, 16'h0030);
        chk("R9 reset mid fetch instr", instr, 16'h0000);
        repeat (2) @(negedge clk);
        #1 chk("R9 no done after reset", {15'd0, instr_done}, 16'd0);
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) ram_m[k] = 8'h00;
        for (int k = 0; k < 4; k++) io_m[k] = 8'h00;
        t_reset();
        t_eff_addr();
        t_decode();
        t_store();
        t_fetch();
        t_stall();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule